// File: doc/BRIEF.md
# Successive Approximation Conversion Sequencer

This block runs one 8-bit analog-to-digital conversion by successive approximation, using an external DAC and a one-bit comparator that tells whether the analog input lies above the DAC output. A conversion is requested with a start pulse. The sequencer then waits for a free-running 2-bit sample-period counter to reach the value it expects. It keeps the sample-and-hold in sample mode long enough for the input to settle, then switches to hold and finds the code one bit at a time, from the top bit down.

When the last bit is decided, the sequencer drops hold and presents the code with a one-clock done strobe. The expected counter value advances by a 2-bit rate step after every conversion. With the counter ticking every 63.5 µs, steps of 1, 2 and 3 give sample rates of about 15.75, 7.875 and 5.25 kHz.

Top module: `sar_conv_seq`

## Requirements
- R1: After reset, hold_o is 0, done_o is 0, dac_o is 0, result_o is 0 and the expected counter value is 0.
- R2: A start_i pulse while idle begins a conversion and captures rate_i. hold_o stays 0 for as long as phase_i differs from the expected value.
- R3: At the first clock edge where phase_i equals the expected value, the expected value for the next conversion becomes the current one plus the captured rate step, modulo 4.
- R4: After that edge, hold_o stays 0 (sample mode) for exactly SETTLE_CLKS clocks before it rises. The default of 350 clocks at 50 MHz gives 7 µs.
- R5: When hold_o rises, dac_o is 0x80. Bits are decided in order from bit 7 down to bit 0.
- R6: Each trial code stays on dac_o for CMP_DELAY+1 clocks, and cmp_i is sampled in the last of them. cmp_i = 1 means the input is above the DAC output. If cmp_i = 1 the bit under test is kept, otherwise it is cleared. The next lower bit is then set for the following trial.
- R7: After the eighth decision, hold_o falls and done_o is 1 for exactly one clock in the same cycle. result_o carries the final code and keeps it until the next done.
- R8: A start_i pulse during a conversion is ignored: no second conversion follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Conversion request |
| rate_i | input | 2 | Counter step between conversions |
| phase_i | input | 2 | Sample-period counter |
| cmp_i | input | 1 | 1 when the input is above the DAC output |
| dac_o | output | DATA_W | Trial code driven to the DAC |
| hold_o | output | 1 | 1 = hold, 0 = sample |
| result_o | output | DATA_W | Last converted code |
| done_o | output | 1 | One-clock completion strobe |

## Verification
The bench builds the block with SETTLE_CLKS = 4 and CMP_DELAY = 1, so that a full conversion takes a few dozen clocks. This short conversion makes it practical to sweep all 256 input levels, with the bench driving the counter directly and rotating the rate step through 1, 2 and 3. The comparator is modelled as an input sitting half a step above a chosen level. The expected trial codes, settle length and result therefore follow arithmetically from that level. Some conversions also carry a start pulse in mid-conversion, followed by an idle window with a matching counter value, to show that the pulse is ignored.

// File: rtl/sar_conv_seq.sv
`timescale 1ns/1ps
module sar_conv_seq #(
  parameter int DATA_W      = 8,
  parameter int SETTLE_CLKS = 350,
  parameter int CMP_DELAY   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        rate_i,
  input  logic [1:0]        phase_i,
  input  logic              cmp_i,
  output logic [DATA_W-1:0] dac_o,
  output logic              hold_o,
  output logic [DATA_W-1:0] result_o,
  output logic              done_o
);
  localparam int MAXC = (SETTLE_CLKS > CMP_DELAY + 1) ? SETTLE_CLKS : CMP_DELAY + 1;
  localparam int CW   = $clog2(MAXC + 1);
  localparam int BW   = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  typedef enum logic [1:0] {S_IDLE, S_ALIGN, S_SETTLE, S_TRIAL} st_t;

  st_t               st;
  logic [1:0]        exp_q, rate_q;
  logic [CW-1:0]     cnt;
  logic [BW-1:0]     bit_q;
  logic [DATA_W-1:0] code_q, res_q, decided;
  logic              done_q;

  wire last_settle = (cnt == CW'(SETTLE_CLKS - 1));
  wire decide      = (cnt == CW'(CMP_DELAY));

  always_comb begin
    decided        = code_q;
    decided[bit_q] = cmp_i;
    if (bit_q != '0) decided[bit_q - 1'b1] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      exp_q  <= '0;
      rate_q <= '0;
      cnt    <= '0;
      bit_q  <= '0;
      code_q <= '0;
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start_i) begin
          st     <= S_ALIGN;
          rate_q <= rate_i;
        end
        S_ALIGN: if (phase_i == exp_q) begin
          exp_q <= exp_q + rate_q;
          st    <= S_SETTLE;
          cnt   <= '0;
        end
        S_SETTLE: if (last_settle) begin
          st     <= S_TRIAL;
          cnt    <= '0;
          code_q <= DATA_W'(1) << (DATA_W - 1);
          bit_q  <= BW'(DATA_W - 1);
        end else begin
          cnt <= cnt + 1'b1;
        end
        S_TRIAL: if (decide) begin
          code_q <= decided;
          cnt    <= '0;
          if (bit_q == '0) begin
            st     <= S_IDLE;
            res_q  <= decided;
            done_q <= 1'b1;
          end else begin
            bit_q <= bit_q - 1'b1;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign dac_o    = code_q;
  assign hold_o   = (st == S_TRIAL);
  assign result_o = res_q;
  assign done_o   = done_q;
endmodule

module sar_conv_seq_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] dac_o,
  input logic              hold_o,
  input logic              done_o
);
  assert_first_trial_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_o) |-> dac_o == (DATA_W'(1) << (DATA_W - 1)));
  assert_done_no_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !hold_o);
  assert_release_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_o) |-> done_o);
  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_trial_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_o && $past(hold_o)) |-> $countones(dac_o ^ $past(dac_o)) <= 2);
endmodule

bind sar_conv_seq sar_conv_seq_chk #(.DATA_W(DATA_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .dac_o(dac_o), .hold_o(hold_o), .done_o(done_o));

// File: tb/test_sar_conv_seq.sv
`timescale 1ns/1ps
module test_sar_conv_seq;
  localparam int S = 4;
  localparam int D = 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [1:0] rate_i = '0;
  logic [1:0] phase_i = '0;
  logic [7:0] dac_o, result_o;
  logic       hold_o, done_o;
  int         vin = 0;
  int         errors = 0;
  int         checks = 0;
  bit         finished = 1'b0;

  wire cmp_i = (int'(dac_o) <= vin);

  sar_conv_seq #(.DATA_W(8), .SETTLE_CLKS(S), .CMP_DELAY(D)) i_sar_conv_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .rate_i(rate_i), .phase_i(phase_i),
    .cmp_i(cmp_i), .dac_o(dac_o), .hold_o(hold_o), .result_o(result_o), .done_o(done_o));

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic convert(input int level, input int rate, input bit poke, inout int expph);
    int lowcnt;
    int acc;
    int trial;
    bit bad;
    vin = level;
    @(negedge clk);
    start_i = 1'b1;
    rate_i  = 2'(rate);
    phase_i = 2'(expph + 1);
    @(negedge clk);
    start_i = 1'b0;
    bad = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (hold_o) bad = 1'b1;
    end
    check(!bad, "R2 hold low while unaligned", int'(bad), 0);
    phase_i = 2'(expph);
    lowcnt = 0;
    do begin
      @(negedge clk);
      phase_i = 2'(expph + 2);
      if (!hold_o) lowcnt++;
    end while (!hold_o && lowcnt < 100);
    check(hold_o, "R3 alignment on expected counter value", int'(hold_o), 1);
    check(lowcnt == S, "R4 settle length", lowcnt, S);
    check(dac_o == 8'h80, "R5 first trial code", int'(dac_o), 128);
    acc = 0;
    bad = 1'b0;
    for (int b = 7; b >= 0; b--) begin
      trial = acc | (1 << b);
      for (int k = 0; k <= D; k++) begin
        if (int'(dac_o) != trial || !hold_o) begin
          if (!bad) $display("FAIL R6 trial bit %0d actual=%0d expected=%0d", b, dac_o, trial);
          bad = 1'b1;
        end
        if (poke && b == 4 && k == 0) start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
      end
      if (trial <= level) acc = trial;
    end
    checks++;
    if (bad) errors++;
    check(done_o && !hold_o, "R7 done with hold released", {30'd0, done_o, hold_o}, 2);
    check(int'(result_o) == level, "R6 result code", int'(result_o), level);
    @(negedge clk);
    check(!done_o && int'(result_o) == level, "R7 single done, result kept", int'(result_o) + (done_o ? 1000 : 0), level);
    expph = (expph + rate) & 3;
    if (poke) begin
      phase_i = 2'(expph);
      bad = 1'b0;
      for (int k = 0; k < S + 6; k++) begin
        @(negedge clk);
        if (hold_o || done_o) bad = 1'b1;
      end
      check(!bad, "R8 start during conversion ignored", int'(bad), 0);
    end
  endtask

  initial begin
    #(20 * 150000);
    check(1'b0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    int expph;
    expph = 0;
    repeat (3) @(negedge clk);
    check(!hold_o && !done_o && dac_o == 0 && result_o == 0, "R1 reset outputs",
          int'(dac_o) + int'(result_o) + int'(hold_o) + int'(done_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!hold_o && !done_o, "R1 idle after reset", int'(hold_o) + int'(done_o), 0);
    for (int v = 0; v < 256; v++)
      convert(v, (v % 3) + 1, (v % 37) == 5, expph);
    summary();
  end
endmodule